// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block holds the status/control word of a floating-point unit. Software writes the word through a write port; each completed arithmetic operation reports five IEEE exception indications, which replace the flag field and accumulate into the cause field. When a cause bit is present whose enable bit is also set, the block issues a one-cycle exception request carrying a fixed vector code. The word also drives the rounding-mode select and the flush-to-zero control of the datapath.

Compares (equal and greater-than) report through the same block. An ordered compare sets or clears a condition bit from the comparison outcome. An unordered compare leaves the condition bit alone and updates the exception state, using the exception bits present on the operation exception bus in that cycle.

Top module: `fp_status_ctl`

## Requirements
- R1: A write stores `wr_data & 32'h0007_FFFF` into the word; it is visible on `csr` one cycle later. Layout: bits 1:0 rounding mode, 6:2 flags, 11:7 enables, 17:12 cause, 18 denormal control; within flags, enables and the low five cause bits the order from low to high is inexact, underflow, overflow, divide-by-zero, invalid (same as `op_exc` bits 0..4).
- R2: `round_trunc` is 1 exactly when the rounding-mode field equals 2'b01; the values 2'b00, 2'b10 and 2'b11 give 0 (round to nearest even).
- R3: `flush_zero` follows bit 18 of the word.
- R4: An operation update (one cycle after `op_valid`) replaces the whole flag field with `op_exc`, so flags from earlier operations do not remain; an update with `op_exc == 0` clears the flags.
- R5: An operation update ORs `op_exc` into cause bits 16:12; earlier cause bits remain set; bit 17 and the other fields are unchanged.
- R6: One cycle after an update with nonzero `op_exc` whose resulting cause ANDed with the enables is nonzero, `exc_req` is 1 for one cycle and `exc_vec` is 12'h120.
- R7: No request is raised when the resulting cause has no enabled bit, or when `op_exc` is zero, even if older cause bits are enabled; `exc_vec` is 0 whenever `exc_req` is 0.
- R8: A write in the same cycle as an operation update wins: the word takes the written value and no request is raised.
- R9: A compare with `cmp_unordered` 0 sets `t_flag` to `cmp_true` one cycle later; with `cmp_unordered` 1 `t_flag` holds and the exception state is updated from `op_exc` as in R4 to R6.
- R10: After reset the word is 0, `t_flag` is 0 and `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data |
| op_valid | input | 1 | An operation completed this cycle |
| op_exc | input | 5 | Exception bits: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid |
| cmp_valid | input | 1 | A compare completed this cycle |
| cmp_unordered | input | 1 | The compare was unordered |
| cmp_true | input | 1 | Outcome of an ordered compare |
| csr | output | 32 | Current status word |
| round_trunc | output | 1 | 1 selects truncation, 0 round to nearest even |
| flush_zero | output | 1 | Denormal flush-to-zero control |
| t_flag | output | 1 | Compare condition bit |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 12 | Vector code of the request |

## Verification
On every cycle the assertions check that a write lands masked in the word, that an update copies the exception bits into the flags and never clears a cause bit, that a request only follows an update with exception bits and always carries its code, and that an unordered compare leaves the condition bit alone. Which enable patterns trap and which do not, the decoding of every rounding-mode value, and the loss of an update that collides with a write are shown only by the bench's scenarios, which compare the outputs against values worked out from the requirements.

// File: rtl/fp_status_ctl.sv
module fp_status_ctl #(
  parameter int DATA_W = 32,
  parameter int NEXC = 5,
  parameter int VEC_W = 12,
  parameter logic [DATA_W-1:0] WR_MASK = 32'h0007_FFFF,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_valid,
  input  logic [NEXC-1:0]   op_exc,
  input  logic              cmp_valid,
  input  logic              cmp_unordered,
  input  logic              cmp_true,
  output logic [DATA_W-1:0] csr,
  output logic              round_trunc,
  output logic              flush_zero,
  output logic              t_flag,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec
);
  localparam int RM_LO  = 0;
  localparam int FLG_LO = RM_LO + 2;
  localparam int EN_LO  = FLG_LO + NEXC;
  localparam int CAU_LO = EN_LO + NEXC;
  localparam int CAU_W  = NEXC + 1;
  localparam int DN_BIT = CAU_LO + CAU_W;
  localparam logic [1:0] RM_TRUNC = 2'b01;

  logic [DATA_W-1:0] csr_q, csr_upd;
  logic [NEXC-1:0]   cause_new;
  logic              upd, trap;

  assign upd       = (op_valid | (cmp_valid & cmp_unordered)) & ~wr_en;
  assign cause_new = csr_q[CAU_LO +: NEXC] | op_exc;
  assign trap      = upd & (|op_exc) & (|(cause_new & csr_q[EN_LO +: NEXC]));

  always_comb begin
    csr_upd = csr_q;
    csr_upd[FLG_LO +: NEXC] = op_exc;
    csr_upd[CAU_LO +: NEXC] = cause_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q   <= '0;
      exc_req <= 1'b0;
      t_flag  <= 1'b0;
    end else begin
      if (wr_en)    csr_q <= wr_data & WR_MASK;
      else if (upd) csr_q <= csr_upd;
      exc_req <= trap;
      if (cmp_valid && !cmp_unordered) t_flag <= cmp_true;
    end
  end

  assign csr         = csr_q;
  assign round_trunc = (csr_q[RM_LO +: 2] == RM_TRUNC);
  assign flush_zero  = csr_q[DN_BIT];
  assign exc_vec     = exc_req ? TRAP_VEC : '0;
endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        op_valid,
  input logic [4:0]  op_exc,
  input logic        cmp_valid,
  input logic        cmp_unordered,
  input logic [31:0] csr,
  input logic        t_flag,
  input logic        exc_req,
  input logic [11:0] exc_vec
);
  p_wr_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> csr == ($past(wr_data) & 32'h0007_FFFF));

  p_flags_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en) |=> csr[6:2] == $past(op_exc));

  p_cause_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en) |=> (csr[16:12] & $past(csr[16:12])) == $past(csr[16:12]));

  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past((op_valid || (cmp_valid && cmp_unordered)) && !wr_en && (op_exc != 5'd0)));

  p_req_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_vec == 12'h120);

  p_no_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> exc_vec == 12'h000);

  p_t_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_unordered) |=> $stable(t_flag));
endmodule

bind fp_status_ctl fp_status_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .op_valid(op_valid), .op_exc(op_exc), .cmp_valid(cmp_valid),
  .cmp_unordered(cmp_unordered), .csr(csr), .t_flag(t_flag),
  .exc_req(exc_req), .exc_vec(exc_vec)
);

// File: tb/fp_status_ctl_tb.sv
module fp_status_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic op_valid = 1'b0;
  logic [4:0] op_exc = '0;
  logic cmp_valid = 1'b0, cmp_unordered = 1'b0, cmp_true = 1'b0;
  logic [31:0] csr;
  logic round_trunc, flush_zero, t_flag, exc_req;
  logic [11:0] exc_vec;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fp_status_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_valid(op_valid), .op_exc(op_exc), .cmp_valid(cmp_valid),
    .cmp_unordered(cmp_unordered), .cmp_true(cmp_true), .csr(csr),
    .round_trunc(round_trunc), .flush_zero(flush_zero), .t_flag(t_flag),
    .exc_req(exc_req), .exc_vec(exc_vec)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; op_valid = 0; cmp_valid = 0; cmp_unordered = 0; cmp_true = 0; op_exc = 0;
  endtask

  task automatic do_write(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic do_op(logic [4:0] e);
    @(negedge clk); op_valid = 1; op_exc = e;
    @(negedge clk); idle();
  endtask

  function automatic logic [31:0] word(logic [1:0] rm, logic [4:0] en, logic [5:0] cau, logic dn);
    return {13'd0, dn, cau, en, 5'd0, rm};
  endfunction

  task automatic t_reset();
    check("R10 csr", csr, 0);
    check("R10 t_flag", {31'd0, t_flag}, 0);
    check("R10 exc_req", {31'd0, exc_req}, 0);
  endtask

  task automatic t_write_mask();
    do_write(32'hFFFF_FFFF);
    check("R1 mask all ones", csr, 32'h0007_FFFF);
    do_write(32'hA5A5_1234);
    check("R1 mask pattern", csr, 32'h0005_1234);
  endtask

  task automatic t_round();
    for (int m = 0; m < 4; m++) begin
      do_write({30'd0, 2'(m)});
      check("R2 round_trunc", {31'd0, round_trunc}, (m == 1) ? 1 : 0);
    end
  endtask

  task automatic t_flush();
    do_write(32'h0004_0000);
    check("R3 flush set", {31'd0, flush_zero}, 1);
    do_write(32'h0003_FFFF);
    check("R3 flush clear", {31'd0, flush_zero}, 0);
  endtask

  task automatic t_flags_cause();
    do_write(word(2'b10, 5'd0, 6'b100000, 1'b1));
    do_op(5'b10001);
    check("R4 flags first", {27'd0, csr[6:2]}, 5'b10001);
    check("R5 cause first", csr, word(2'b10, 5'd0, 6'b110001, 1'b1) | {25'd0, 5'b10001, 2'b0});
    check("R7 no enable no req", {31'd0, exc_req}, 0);
    do_op(5'b00010);
    check("R4 flags replaced", {27'd0, csr[6:2]}, 5'b00010);
    check("R5 cause accumulates", {26'd0, csr[17:12]}, 6'b110011);
    do_op(5'b00000);
    check("R4 flags cleared", {27'd0, csr[6:2]}, 0);
    check("R5 cause kept", {26'd0, csr[17:12]}, 6'b110011);
  endtask

  task automatic t_trap();
    do_write(word(2'b00, 5'b10000, 6'd0, 1'b0));
    do_op(5'b01000);
    check("R7 unmatched enable", {31'd0, exc_req}, 0);
    check("R7 vec idle", {20'd0, exc_vec}, 0);
    do_op(5'b10000);
    check("R6 req raised", {31'd0, exc_req}, 1);
    check("R6 vec code", {20'd0, exc_vec}, 12'h120);
    @(negedge clk);
    check("R6 one cycle pulse", {31'd0, exc_req}, 0);
    do_op(5'b00000);
    check("R7 zero exc no req", {31'd0, exc_req}, 0);
    do_op(5'b00001);
    check("R6 old enabled cause traps", {31'd0, exc_req}, 1);
  endtask

  task automatic t_priority();
    do_write(word(2'b00, 5'b11111, 6'd0, 1'b0));
    @(negedge clk); wr_en = 1; wr_data = 32'h0000_0F83; op_valid = 1; op_exc = 5'b11111;
    @(negedge clk); idle();
    check("R8 write wins", csr, 32'h0000_0F83);
    check("R8 no req", {31'd0, exc_req}, 0);
  endtask

  task automatic t_compare();
    do_write(word(2'b00, 5'b10000, 6'd0, 1'b0));
    @(negedge clk); cmp_valid = 1; cmp_true = 1;
    @(negedge clk); idle();
    check("R9 ordered sets T", {31'd0, t_flag}, 1);
    @(negedge clk); cmp_valid = 1; cmp_unordered = 1; cmp_true = 0; op_exc = 5'b10000;
    @(negedge clk); idle();
    check("R9 unordered holds T", {31'd0, t_flag}, 1);
    check("R9 unordered flags", {27'd0, csr[6:2]}, 5'b10000);
    check("R9 unordered traps", {31'd0, exc_req}, 1);
    @(negedge clk); cmp_valid = 1; cmp_true = 0;
    @(negedge clk); idle();
    check("R9 ordered clears T", {31'd0, t_flag}, 0);
  endtask

  initial begin
    fork
      begin
        #1; t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_mask();
        t_round();
        t_flush();
        t_flags_cause();
        t_trap();
        t_priority();
        t_compare();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule